// File: doc/BRIEF.md
# I2C Clock Divider Parameter Search

This block chooses the prescaler setting for an I2C master's serial clock. A request carries two numbers: the ratio of the module clock to the wanted bus rate, and the module clock frequency in kHz. The engine derives a digital glitch-filter sampling value from the clock frequency. It then walks a fixed 8 x 8 grid of prescaler factor pairs, one candidate per clock, and keeps the smallest achievable divider that is strictly larger than the request. A divider at least as large as the request keeps the bus at or below the requested rate.

A request is offered on a valid/ready pair. `in_ready` is high only while the engine is idle. A request is taken on a rising clock edge where `in_valid` and `in_ready` are both high. While a search runs, `in_ready` stays low and any value on the request inputs is ignored. The engine has no output back-pressure. When a search ends, `done` pulses for one cycle, and the encoded divider register byte, the filter value, the chosen divider and a found flag update in that same cycle. These four results then hold until the next `done`.

Top module: `i2c_div_search`

## Requirements
- R1: After reset and between searches `in_ready` is 1. A request is accepted on an edge where `in_valid` and `in_ready` are both 1. From that edge until the search ends, `in_ready` is 0, and `in_valid`, `in_div` and `in_khz` have no effect on any result.
- R2: The filter value is floor(5 * in_khz / 100000). A result of 0 is replaced by 1. It appears on `filt_code`.
- R3: A request divider above 65535 is treated as 65535 (saturated, not truncated). An input of 70000 therefore finds no candidate.
- R4: Candidates are visited with the outer factor A in the order 10, 12, 14, 16, 18, 20, 24, 30 (index ga = 4..11). Inside each outer step, B = 16 << gb for gb = 0..7. Each candidate divider is B * (A + floor(3 * filter / B) * 2).
- R5: A candidate replaces the current best only if it is strictly greater than the (saturated) request and strictly less than the current best. The best starts at 2^32 - 1. On a tie, the earlier candidate in the R4 order is kept.
- R6: `fdr_code` for the winning candidate has bits [4:2] = gb, bits [1:0] = ga[1:0], bit 5 = ga[2], and bits [7:6] = 0. Bit 3 of ga is not encoded.
- R7: When no candidate qualifies, `fdr_code` = 0x31, `found` = 0 and `eff_div` = 0xFFFFFFFF. Otherwise `found` = 1 and `eff_div` is the winning divider.
- R8: `done` is high for exactly one cycle, 65 clock edges after the accepting edge. All four results change only on that edge and hold otherwise.
- R9: During and after reset, `in_ready` = 1, `done` = 0, and `fdr_code`, `filt_code`, `eff_div` and `found` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Module clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request offered |
| in_ready | output | 1 | Engine idle, request can be taken |
| in_div | input | 32 | Requested clock-to-bus divider |
| in_khz | input | 20 | Module clock frequency in kHz |
| done | output | 1 | One-cycle completion pulse |
| fdr_code | output | 8 | Encoded divider register byte |
| filt_code | output | 8 | Filter sampling value |
| eff_div | output | 32 | Chosen effective divider |
| found | output | 1 | A grid candidate qualified |

## Verification
The accepting edge starts a fixed schedule. Candidates are registered on edges 1 to 64 after it. The last comparison and the result update fall on edge 65, so `done` and every result are due exactly 65 edges after acceptance, and `in_ready` rises on that same edge. The bench model counts edges from the same acceptance and compares `in_ready`, `done` and all results on each falling edge. A result that arrives one edge early or late, or that moves outside its `done` cycle, is therefore a miscompare. Directed requests cover a zero filter, a request one below and exactly at the largest candidate, a saturating request, requests offered while busy, and a request taken in the `done` cycle.

// File: rtl/i2cds_pkg.sv
package i2cds_pkg;

  localparam int GRID_LOG2 = 3;
  localparam int GRID_SIZE = 1 << GRID_LOG2;
  localparam int IDX_W = 2 * GRID_LOG2;
  localparam int CAND_N = GRID_SIZE * GRID_SIZE;
  localparam logic [7:0] FDR_NONE = 8'h31;
  localparam int B_BASE_SHIFT = 4;

  // Outer factor for grid row gi (ga = gi + 4)
  function automatic logic [5:0] outer_factor(input logic [GRID_LOG2-1:0] gi);
    case (gi)
      3'd0: outer_factor = 6'd10;
      3'd1: outer_factor = 6'd12;
      3'd2: outer_factor = 6'd14;
      3'd3: outer_factor = 6'd16;
      3'd4: outer_factor = 6'd18;
      3'd5: outer_factor = 6'd20;
      3'd6: outer_factor = 6'd24;
      default: outer_factor = 6'd30;
    endcase
  endfunction

  // Scrambled register byte: ga[2] -> bit5, gb -> bits 4:2, ga[1:0] -> bits 1:0
  function automatic logic [7:0] pack_code(input logic [GRID_LOG2-1:0] gi,
                                           input logic [GRID_LOG2-1:0] gb);
    logic [3:0] ga;
    ga = {1'b0, gi} + 4'd4;
    pack_code = {2'b00, ga[2], gb, ga[1:0]};
  endfunction

endpackage

// File: rtl/ids_filter.sv
module ids_filter #(
  parameter int KHZ_W  = 20,
  parameter int FILT_W = 8
) (
  input  logic [KHZ_W-1:0]  khz,
  output logic [FILT_W-1:0] filt
);
  localparam int Q_W = KHZ_W + 3;

  logic [Q_W-1:0] scaled;
  logic [Q_W-1:0] quot;

  always_comb begin
    scaled = Q_W'(khz) * Q_W'(5);
    quot   = scaled / Q_W'(100000);
  end

  generate
    if (FILT_W < Q_W) begin : g_narrow
      assign filt = (quot == '0) ? FILT_W'(1) : quot[FILT_W-1:0];
    end else begin : g_wide
      assign filt = (quot == '0) ? FILT_W'(1) : FILT_W'(quot);
    end
  endgenerate
endmodule

// File: rtl/ids_cand_gen.sv
module ids_cand_gen
  import i2cds_pkg::*;
#(
  parameter int FILT_W = 8,
  parameter int DIV_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  input  logic [FILT_W-1:0] filt,
  output logic              cand_vld,
  output logic              cand_last,
  output logic [DIV_W-1:0]  cand_div,
  output logic [7:0]        cand_code
);
  logic [GRID_LOG2-1:0] gi, gb;
  logic [3:0]           sh;
  logic [DIV_W-1:0]     corr, base, prod;

  always_comb begin
    gi   = idx[IDX_W-1:GRID_LOG2];
    gb   = idx[GRID_LOG2-1:0];
    sh   = {1'b0, gb} + 4'(B_BASE_SHIFT);
    corr = (DIV_W'(filt) * DIV_W'(3)) >> sh;
    base = DIV_W'(outer_factor(gi)) + (corr << 1);
    prod = base << sh;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cand_vld  <= 1'b0;
      cand_last <= 1'b0;
      cand_div  <= '0;
      cand_code <= '0;
    end else begin
      cand_vld  <= en;
      cand_last <= en && (idx == IDX_W'(CAND_N - 1));
      if (en) begin
        cand_div  <= prod;
        cand_code <= pack_code(gi, gb);
      end
    end
  end

  AST_LAST_IS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    cand_last |-> cand_vld) else $error("last without valid"); // R8
endmodule

// File: rtl/ids_best_track.sv
module ids_best_track
  import i2cds_pkg::*;
#(
  parameter int FILT_W = 8,
  parameter int DIV_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              vld,
  input  logic              last,
  input  logic [DIV_W-1:0]  cand_div,
  input  logic [7:0]        cand_code,
  input  logic [DIV_W-1:0]  req,
  input  logic [FILT_W-1:0] filt_in,
  output logic              done,
  output logic [7:0]        res_code,
  output logic [FILT_W-1:0] res_filt,
  output logic [DIV_W-1:0]  res_div,
  output logic              res_found
);
  logic [DIV_W-1:0] best_q, best_n;
  logic [7:0]       code_q, code_n;
  logic             fnd_q, fnd_n;
  logic             win;

  always_comb begin
    win    = vld && (cand_div > req) && (cand_div < best_q);
    best_n = win ? cand_div  : best_q;
    code_n = win ? cand_code : code_q;
    fnd_n  = win | fnd_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      best_q    <= '1;
      code_q    <= FDR_NONE;
      fnd_q     <= 1'b0;
      done      <= 1'b0;
      res_code  <= '0;
      res_filt  <= '0;
      res_div   <= '0;
      res_found <= 1'b0;
    end else begin
      done <= vld && last;
      if (clr) begin
        best_q <= '1;
        code_q <= FDR_NONE;
        fnd_q  <= 1'b0;
      end else if (vld) begin
        best_q <= best_n;
        code_q <= code_n;
        fnd_q  <= fnd_n;
      end
      if (vld && last) begin
        res_code  <= code_n;
        res_filt  <= filt_in;
        res_div   <= best_n;
        res_found <= fnd_n;
      end
    end
  end

  AST_BEST_ABOVE_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    (fnd_q && !clr) |-> (best_q > req)) else $error("best not above request"); // R5
  AST_BEST_NEVER_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    (vld && !clr) |=> (best_q <= $past(best_q))) else $error("best grew"); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done) else $error("done longer than one cycle"); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(res_code) && $stable(res_div) && $stable(res_found)))
    else $error("result moved outside done"); // R8
  AST_NONE_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !res_found) |-> (res_code == FDR_NONE && res_div == '1))
    else $error("default code wrong"); // R7
  AST_CODE_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (res_code[7:6] == 2'b00)) else $error("code high bits set"); // R6
endmodule

// File: rtl/i2c_div_search.sv
module i2c_div_search
  import i2cds_pkg::*;
#(
  parameter int REQ_W   = 32,
  parameter int KHZ_W   = 20,
  parameter int FILT_W  = 8,
  parameter int DIV_W   = 32,
  parameter int SAT_MAX = 65535
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [REQ_W-1:0]  in_div,
  input  logic [KHZ_W-1:0]  in_khz,
  output logic              done,
  output logic [7:0]        fdr_code,
  output logic [FILT_W-1:0] filt_code,
  output logic [DIV_W-1:0]  eff_div,
  output logic              found
);
  localparam logic [REQ_W-1:0] SAT_LIM = REQ_W'(SAT_MAX);

  logic              running;
  logic [IDX_W-1:0]  idx;
  logic [DIV_W-1:0]  req_q;
  logic [FILT_W-1:0] filt_q, filt_w;
  logic [REQ_W-1:0]  req_sat;
  logic              accept;
  logic              cand_vld, cand_last;
  logic [DIV_W-1:0]  cand_div;
  logic [7:0]        cand_code;

  assign in_ready = !running && !cand_vld;
  assign accept   = in_valid && in_ready;
  assign req_sat  = (in_div > SAT_LIM) ? SAT_LIM : in_div;

  ids_filter #(.KHZ_W(KHZ_W), .FILT_W(FILT_W)) u_filt (
    .khz  (in_khz),
    .filt (filt_w)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running <= 1'b0;
      idx     <= '0;
      req_q   <= '0;
      filt_q  <= '0;
    end else if (accept) begin
      running <= 1'b1;
      idx     <= '0;
      req_q   <= DIV_W'(req_sat);
      filt_q  <= filt_w;
    end else if (running) begin
      idx <= idx + 1'b1;
      if (idx == IDX_W'(CAND_N - 1)) running <= 1'b0;
    end
  end

  ids_cand_gen #(.FILT_W(FILT_W), .DIV_W(DIV_W)) u_gen (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (running),
    .idx       (idx),
    .filt      (filt_q),
    .cand_vld  (cand_vld),
    .cand_last (cand_last),
    .cand_div  (cand_div),
    .cand_code (cand_code)
  );

  ids_best_track #(.FILT_W(FILT_W), .DIV_W(DIV_W)) u_best (
    .clk       (clk),
    .rst_n     (rst_n),
    .clr       (accept),
    .vld       (cand_vld),
    .last      (cand_last),
    .cand_div  (cand_div),
    .cand_code (cand_code),
    .req       (req_q),
    .filt_in   (filt_q),
    .done      (done),
    .res_code  (fdr_code),
    .res_filt  (filt_code),
    .res_div   (eff_div),
    .res_found (found)
  );

  AST_REQ_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !in_ready) |=> $stable(req_q)) else $error("request changed while busy"); // R1
  AST_FILT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (filt_q != '0)) else $error("filter zero during search"); // R2
  AST_REQ_SATURATED: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (req_q <= DIV_W'(SAT_MAX))) else $error("request above limit"); // R3
endmodule

// File: tb/sim_i2c_div_search.sv
module sim_i2c_div_search;
  localparam int CLK_PERIOD = 10;
  localparam int LATENCY = 65;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_div = '0;
  logic [19:0] in_khz = '0;
  logic        in_ready, done, found;
  logic [7:0]  fdr_code, filt_code;
  logic [31:0] eff_div;

  int vectors = 0;
  int errors = 0;
  bit summary_done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2c_div_search u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_div(in_div), .in_khz(in_khz), .done(done), .fdr_code(fdr_code),
    .filt_code(filt_code), .eff_div(eff_div), .found(found)
  );

  // Behavioural reference of one full search
  task automatic ref_calc(input longint rq_in, input int khz,
                          output int code, output int filt,
                          output longint dv, output bit fnd);
    int avals[8];
    longint rq, best, c, b;
    avals = '{10, 12, 14, 16, 18, 20, 24, 30};
    rq = (rq_in > 65535) ? 65535 : rq_in;
    filt = (5 * khz) / 100000;
    if (filt == 0) filt = 1;
    best = 64'hFFFF_FFFF;
    code = 8'h31;
    fnd = 0;
    for (int ga = 4; ga <= 11; ga++) begin
      for (int gb = 0; gb < 8; gb++) begin
        b = 16 << gb;
        c = b * (avals[ga-4] + ((3 * filt) / b) * 2);
        if (c > rq && c < best) begin
          best = c;
          code = (gb << 2) | (ga & 3) | ((ga & 4) << 3);
          fnd = 1;
        end
      end
    end
    dv = best;
  endtask

  // Cycle model
  bit     m_busy, m_done, m_found, p_found;
  int     m_cnt, m_code, m_filt, p_code, p_filt;
  longint m_div, p_div;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_cnt = 0; m_done = 0;
      m_code = 0; m_filt = 0; m_div = 0; m_found = 0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == LATENCY) begin
          m_busy = 0; m_done = 1;
          m_code = p_code; m_filt = p_filt; m_div = p_div; m_found = p_found;
        end
      end else if (in_valid) begin
        m_busy = 1; m_cnt = 0;
        ref_calc(longint'(in_div), int'(in_khz), p_code, p_filt, p_div, p_found);
      end
    end
  end

  always @(negedge clk) begin
    vectors++;
    if (in_ready !== !m_busy) begin
      errors++; $display("FAIL R1 in_ready got %0b exp %0b", in_ready, !m_busy);
    end
    if (done !== m_done) begin
      errors++; $display("FAIL R8 done got %0b exp %0b", done, m_done);
    end
    if (fdr_code !== 8'(m_code)) begin
      errors++; $display("FAIL R6 fdr_code got %02h exp %02h", fdr_code, 8'(m_code));
    end
    if (filt_code !== 8'(m_filt)) begin
      errors++; $display("FAIL R2 filt_code got %0d exp %0d", filt_code, m_filt);
    end
    if (eff_div !== 32'(m_div)) begin
      errors++; $display("FAIL R4 R5 eff_div got %0d exp %0d", eff_div, 32'(m_div));
    end
    if (found !== m_found) begin
      errors++; $display("FAIL R7 found got %0b exp %0b", found, m_found);
    end
  end

  task automatic send(input logic [31:0] rq, input logic [19:0] khz);
    @(negedge clk);
    while (m_busy) @(negedge clk);
    in_valid = 1'b1; in_div = rq; in_khz = khz;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic finish_search();
    @(negedge clk);
    while (m_busy) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic summary();
    if (!summary_done) begin
      summary_done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    // R9: reset state compared on every falling edge while held
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R4 typical request, filter 16
    send(32'd833, 20'd333000); finish_search();
    // R2 filter computes to zero and is forced to one
    send(32'd0, 20'd1000); finish_search();
    // R5 one below the largest candidate: it wins
    send(32'd61439, 20'd100000); finish_search();
    // R5 R7 exactly the largest candidate: strict compare leaves none
    send(32'd61440, 20'd100000); finish_search();
    // R3 70000 saturates (truncation would give 4464 and a hit)
    send(32'd70000, 20'd100000); finish_search();
    send(32'hFFFF_1170, 20'd400000); finish_search();
    // R4 large filter makes the correction term matter
    send(32'd100, 20'd1000000); finish_search();
    send(32'd47, 20'd1048575); finish_search();
    // R1 inputs offered while busy are ignored
    send(32'd300, 20'd200000);
    in_valid = 1'b1; in_div = 32'd5; in_khz = 20'd900000;
    repeat (20) @(negedge clk);
    in_valid = 1'b0;
    finish_search();
    // R8 back-to-back: second request taken in the done cycle
    send(32'd1500, 20'd500000);
    send(32'd2600, 20'd50000);
    finish_search();
    // R5 sweep incl. tie-prone values
    for (int k = 0; k < 12; k++) begin
      send(32'(k * 1531 + 7), 20'(k * 41000 + 3000));
    end
    finish_search();
    repeat (3) @(negedge clk);
    summary();
    $finish;
  end
endmodule